// File: doc/BRIEF.md
# Shared-Bus SRAM Delay-Line Sequencer

This block runs an audio delay line whose storage is a byte-wide single-port SRAM with one shared data bus. A one-hot ring of ten phases advances on every system clock, so each audio sample takes a frame of ten clocks. In each frame the block moves a circular address pointer and requests an ADC conversion. It then reads the byte stored at that address and latches it as the DAC output. After that it releases the SRAM output drivers, puts the converter result on the shared bus and strobes a write, so the new sample replaces the old one at the same location.

Because every frame reads a location and then overwrites it, and the pointer visits all 2^ADDR_W locations in turn, the output is the input delayed by exactly the memory depth in samples. The converters and the RAM array sit outside the block. The shared bus appears as a separate read input (`bus_in`), a drive value (`bus_out`) and a drive enable (`bus_oe`).

Top module: `sram_delay_seq`

## Requirements
- R1: While `rst` is high (synchronous), the pointer and the DAC register are zero, the ring sits in phase 0, `adc_start` and `bus_oe` are low, `sram_we_n` is high and `sram_oe_n` is low.
- R2: Exactly one of the ten phases is active in each clock after reset. The clock in which `rst` is first sampled low is phase 0, and phase p+1 follows phase p, with 9 wrapping to 0, so one frame lasts ten clocks.
- R3: `sram_addr` takes its new value at the start of phase 1 (pointer + 1) and holds it through phase 0 of the next frame. After 2^ADDR_W-1 it wraps to 0.
- R4: `adc_start` is high in phase 1 only, one clock per frame.
- R5: `sram_oe_n` is high in phases 5 and 6 and low in all other phases.
- R6: `bus_oe` is high in phases 5 and 6 only, and `bus_out` then equals `adc_data`. `bus_oe` and an active `sram_oe_n` never coincide.
- R7: `sram_we_n` is low in phase 5 only. In the clock where it returns high, `bus_oe` is still high.
- R8: `dac_out` loads `bus_in` at the start of phase 3 and holds that value until the start of phase 3 of the next frame.
- R9: The byte presented at `adc_data` in frame f appears on `dac_out` from phase 3 of frame f+2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one phase per cycle |
| rst | input | 1 | Synchronous reset, active high |
| adc_start | output | 1 | Conversion request pulse |
| adc_data | input | DATA_W | Converter result |
| sram_addr | output | ADDR_W | SRAM address (circular pointer) |
| bus_in | input | DATA_W | Value read from the shared data bus |
| bus_out | output | DATA_W | Value the block drives onto the shared bus |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write strobe, active low |
| dac_out | output | DATA_W | Registered sample for the DAC |

## Verification
The bench attaches a behavioural SRAM and walks every phase of every frame. An off-by-one phase in the steering would show up at once, either as a write strobe outside the drive window or as bus contention in the clock where the SRAM outputs and the ADC drive hand over. A pointer that moved in the wrong phase, or a DAC capture one clock early or late, would make the DAC read a location other than the one the frame overwrites, so the delay would come out at depth ±1 samples. The bench runs past several pointer wraps with ramp, toggling and scrambled sample patterns, so it catches a delay that is not exactly the memory depth. It also resets in the middle of a frame, just before the write phase, which checks that no write is left half done and that the pointer restarts at zero.

// File: rtl/sram_delay_pkg.sv
package sram_delay_pkg;
    localparam int NUM_PH       = 10;
    localparam int PH_ADVANCE   = 1;
    localparam int PH_CAPTURE   = 3;
    localparam int PH_WRITE     = 5;
    localparam int PH_DRIVE_END = 6;
endpackage

// File: rtl/sdl_phase_ring.sv
module sdl_phase_ring #(
    parameter int NPH = sram_delay_pkg::NUM_PH
) (
    input  logic           clk,
    input  logic           rst,
    output logic [NPH-1:0] ph
);
    typedef struct packed {
        logic [NPH-1:0] ring;
    } ring_st_t;

    ring_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.ring = {st_q.ring[NPH-2:0], st_q.ring[NPH-1]};
        if (rst) begin
            st_d.ring = NPH'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ph = st_q.ring;

    // R2: exactly one active phase, last phase hands over to phase 0
    assert_one_phase_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(ph) == 1);
    assert_ring_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        ph[NPH-1] |=> ph[0]);
endmodule

// File: rtl/sdl_addr_ctr.sv
module sdl_addr_ctr #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
        if (rst) begin
            st_d.ptr = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign addr = st_q.ptr;

    // R3: pointer only moves on the advance request, and wraps to zero
    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(addr));
    assert_addr_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && addr == {ADDR_W{1'b1}}) |=> addr == '0);
endmodule

// File: rtl/sdl_bus_steer.sv
module sdl_bus_steer #(
    parameter int NPH    = sram_delay_pkg::NUM_PH,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPH-1:0]    ph,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adv,
    output logic              capture,
    output logic              adc_start,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              sram_oe_n,
    output logic              sram_we_n
);
    import sram_delay_pkg::*;

    logic drive;
    logic wr;

    always_comb begin
        adv       = 1'b0;
        capture   = 1'b0;
        adc_start = 1'b0;
        drive     = 1'b0;
        wr        = 1'b0;
        for (int i = 0; i < NPH; i++) begin
            adv       |= ph[i] && (i == PH_ADVANCE - 1);
            capture   |= ph[i] && (i == PH_CAPTURE - 1);
            adc_start |= ph[i] && (i == PH_ADVANCE);
            drive     |= ph[i] && (i >= PH_WRITE) && (i <= PH_DRIVE_END);
            wr        |= ph[i] && (i == PH_WRITE);
        end
    end

    assign bus_oe    = drive;
    assign bus_out   = drive ? adc_data : '0;
    assign sram_oe_n = drive;
    assign sram_we_n = !wr;

    // R4: conversion request is a single-clock pulse
    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);
    // R6: the block and the SRAM never drive the bus together
    assert_no_contention_R6: assert property (@(posedge clk) disable iff (rst)
        !(bus_oe && !sram_oe_n));
    // R7: write strobe lies inside the drive window, with hold after release
    assert_we_inside_R7: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> bus_oe);
    assert_we_hold_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> bus_oe);
endmodule

// File: rtl/sram_delay_seq.sv
module sram_delay_seq #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic              adc_start,
    input  logic [DATA_W-1:0] adc_data,
    output logic [ADDR_W-1:0] sram_addr,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] dac_out
);
    import sram_delay_pkg::*;

    localparam int NPH = NUM_PH;

    logic [NPH-1:0] ph;
    logic           adv;
    logic           capture;

    typedef struct packed {
        logic [DATA_W-1:0] dac;
    } out_st_t;

    out_st_t st_d, st_q;

    sdl_phase_ring #(.NPH(NPH)) u_ring (
        .clk (clk),
        .rst (rst),
        .ph  (ph)
    );

    sdl_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .adv  (adv),
        .addr (sram_addr)
    );

    sdl_bus_steer #(.NPH(NPH), .DATA_W(DATA_W)) u_steer (
        .clk       (clk),
        .rst       (rst),
        .ph        (ph),
        .adc_data  (adc_data),
        .adv       (adv),
        .capture   (capture),
        .adc_start (adc_start),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .sram_oe_n (sram_oe_n),
        .sram_we_n (sram_we_n)
    );

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d.dac = bus_in;
        end
        if (rst) begin
            st_d.dac = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dac_out = st_q.dac;

    // R8: DAC register changes only after the capture phase
    assert_dac_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(dac_out));
    // R5: SRAM outputs are off whenever the write strobe is low
    assert_oe_off_in_write_R5: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> sram_oe_n);
endmodule

// File: tb/sim_sram_delay_seq.sv
`timescale 1ns/1ps
module sim_sram_delay_seq;
    localparam int AW = 5;
    localparam int DW = 8;
    localparam int M  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] adc_data = '0;
    logic          adc_start;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] bus_in;
    logic [DW-1:0] bus_out;
    logic          bus_oe;
    logic          sram_oe_n;
    logic          sram_we_n;
    logic [DW-1:0] dac_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [DW-1:0] mem    [M];
    logic [DW-1:0] shadow [M];
    int            fr = 0;
    logic [DW-1:0] prev_dac = '0;

    always #2 clk = ~clk;

    sram_delay_seq #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .adc_start (adc_start),
        .adc_data  (adc_data),
        .sram_addr (sram_addr),
        .bus_in    (bus_in),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .sram_oe_n (sram_oe_n),
        .sram_we_n (sram_we_n),
        .dac_out   (dac_out)
    );

    // behavioural SRAM: reads drive the bus only with outputs enabled
    assign bus_in = !sram_oe_n ? mem[sram_addr] : 8'hEE;

    always @(posedge clk) begin
        if (!sram_we_n) mem[sram_addr] <= bus_oe ? bus_out : 8'hDD;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one frame, entered at the falling edge where phase 0 is current
    task automatic do_frame(input logic [DW-1:0] sample);
        int            wa   = (fr + 1) % M;
        logic [DW-1:0] newd = shadow[wa];
        for (int p = 0; p < 10; p++) begin
            if (p == 0) adc_data = sample;
            check("R2/R4", "adc_start", 32'(adc_start), 32'(p == 1));
            check("R5", "sram_oe_n", 32'(sram_oe_n), 32'(p == 5 || p == 6));
            check("R6", "bus_oe", 32'(bus_oe), 32'(p == 5 || p == 6));
            if (p == 5 || p == 6) check("R6", "bus_out", 32'(bus_out), 32'(sample));
            check("R7", "sram_we_n", 32'(sram_we_n), 32'(p != 5));
            check("R3", "sram_addr", 32'(sram_addr), 32'(p == 0 ? fr % M : wa));
            if (p < 3) check("R8", "dac_out held", 32'(dac_out), 32'(prev_dac));
            else if (p == 3) check("R9", "dac_out delayed", 32'(dac_out), 32'(newd));
            else check("R8", "dac_out held", 32'(dac_out), 32'(newd));
            @(negedge clk);
        end
        shadow[wa] = sample;
        prev_dac   = newd;
        fr++;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "dac_out", 32'(dac_out), 32'h0);
        check("R1", "sram_addr", 32'(sram_addr), 32'h0);
        check("R1", "adc_start", 32'(adc_start), 32'h0);
        check("R1", "bus_oe", 32'(bus_oe), 32'h0);
        check("R1", "sram_we_n", 32'(sram_we_n), 32'h1);
        check("R1", "sram_oe_n", 32'(sram_oe_n), 32'h0);
        rst      = 1'b0;
        fr       = 0;
        prev_dac = '0;
    endtask

    task automatic t_schedule();
        for (int f = 0; f < 2; f++) do_frame(8'h3C + 8'(f));
    endtask

    task automatic t_wrap();
        // ramp pattern, runs the pointer through its wrap to 0 (R3)
        while (fr < M + 2) do_frame(8'(fr * 3 + 1));
    endtask

    task automatic t_delay();
        // alternating and scrambled bytes, each read back one depth later (R9)
        for (int f = 0; f < M; f++) do_frame((f % 2) ? 8'hFF : 8'h00);
        for (int f = 0; f < M + 4; f++) do_frame(8'(f * 37 + 11) ^ 8'h5A);
    endtask

    task automatic t_midreset();
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", "dac_out after mid reset", 32'(dac_out), 32'h0);
        check("R1", "sram_addr after mid reset", 32'(sram_addr), 32'h0);
        check("R1", "sram_we_n after mid reset", 32'(sram_we_n), 32'h1);
        check("R1", "bus_oe after mid reset", 32'(bus_oe), 32'h0);
        rst      = 1'b0;
        fr       = 0;
        prev_dac = '0;
        for (int f = 0; f < M + 2; f++) do_frame(8'(f) ^ 8'hC3);
    endtask

    always @(negedge clk) begin
        if (!rst && bus_oe && !sram_oe_n) begin
            checks++;
            errors++;
            $display("FAIL R6 contention: actual oe_n 0 expected 1 while driving");
        end
    end

    initial begin
        for (int i = 0; i < M; i++) begin
            mem[i]    = 8'(i) ^ 8'hA5;
            shadow[i] = 8'(i) ^ 8'hA5;
        end
        t_reset();
        t_schedule();
        t_wrap();
        t_delay();
        t_midreset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule